// File: doc/BRIEF.md
# Manchester Transmit Encoder with Wide-Pulse Drive Control

This block takes 4-bit nibbles from a media access controller and turns them into a serial Manchester line stream. It runs on a single half-bit clock, so every data bit takes two clock cycles (two cells). For each accepted nibble it produces eight cells, least significant bit first, with no gap between nibbles. A one-cycle request strobe tells the controller when the nibble on the input is taken.

The block also produces a drive-reduction flag next to the line level. A narrow pulse is one cell long. A wide pulse is two cells long and appears when two consecutive bits differ. The flag goes high only during the second cell of a wide pulse. The block finds wide pulses as it goes, by comparing the next cell level with the level now on the line. It does not look ahead in the bit stream. When transmit-enable falls, the line returns to idle at once with full drive, and the bit history is forgotten.

Top module: `mtx_manchester_tx`

## Requirements
- R1: After reset, `line_out` and `drive_low` are 0. While `tx_en` is low, `nibble_req` is 0.
- R2: Nibble bits go out least significant bit first. Each bit takes two cells. A 1 is sent as low then high, and a 0 as high then low.
- R3: The line level always changes between the two cells of a bit.
- R4: The line level changes at a bit boundary only when the two bits are equal. When they differ, the level stays the same across the boundary.
- R5: `drive_low` is 1 exactly in a cell whose level equals the level of the cell just before it, within one burst. That cell is the second half of a wide pulse.
- R6: `drive_low` is never 1 in two consecutive cycles. Narrow pulses and the first cell of a wide pulse always have full drive.
- R7: `nibble_req` is a combinational strobe, high only while `tx_en` is high. It is high in the first enabled cycle from idle, and then in every eighth cycle. `nibble_in` is captured on the clock edge that ends a strobe cycle.
- R8: A cycle with `tx_en` low makes the next `line_out` 0 and the next `drive_low` 0.
- R9: The first cell after idle never has `drive_low` set, even when its level equals the idle level. Bit history does not survive a gap in `tx_en`.
- R10: A wide pulse that spans two nibbles (bit 3 of one nibble and bit 0 of the next) is flagged the same way as a wide pulse inside one nibble.
- R11: The first cell of a burst appears on `line_out` two edges after `tx_en` is first sampled high. Each later cell follows one edge after the one before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit (cell) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low forces idle |
| nibble_in | input | 4 | Next nibble, taken at the end of a `nibble_req` cycle |
| nibble_req | output | 1 | Strobe: `nibble_in` is captured at the coming edge |
| line_out | output | 1 | Encoded line level, 0 when idle |
| drive_low | output | 1 | Request for reduced drive in this cell |

## Verification
Two events can fall in the same cycle: a new nibble is loaded, and the drive decision for the first cell of that nibble is made. That decision depends on the last cell of the previous nibble. Frames are chosen so that bit 3 of one nibble differs from bit 0 of the next, which puts a wide pulse across the load edge. The bench then checks `drive_low` on the first cell of the new nibble against a cell-level model built from the nibble list. A second case drops `tx_en` while a reduced-drive cell is on the line. It checks that the strobe disappears at once, and that the next cell is idle at full drive.

// File: rtl/mtx_pkg.sv
// Package: shared constants and the polarity choice for the Manchester
// transmit encoder. Assumes nothing beyond IEEE 1800-2017.
package mtx_pkg;
    // Default nibble width handed over by the controller.
    localparam int NIB_W_DEF = 4;
    // Cells per data bit (two half-bit cells).
    localparam int CELLS_PER_BIT = 2;

    // Which half of a 1 bit is high.
    typedef enum logic {
        POL_ONE_RISES = 1'b0,   // 1 = low then high
        POL_ONE_FALLS = 1'b1    // 1 = high then low
    } pol_e;
endpackage

// File: rtl/mtx_cell_seq.sv
// Cell sequencer: counts the half-bit cells of the nibble being sent and
// decides when a new nibble is taken. Assumes NIB_W is a power of two.
module mtx_cell_seq
    import mtx_pkg::*;
#(
    parameter int NIB_W = NIB_W_DEF,
    localparam int CELLS = NIB_W * CELLS_PER_BIT,
    localparam int CNT_W = $clog2(CELLS),
    localparam int IDX_W = $clog2(NIB_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    output logic             run,
    output logic             load,
    output logic [IDX_W-1:0] bit_idx,
    output logic             second_half
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CELLS - 1);

    logic [CNT_W-1:0] cnt;

    // Take a nibble on the first enabled cycle and after the last cell.
    always_comb begin
        load = tx_en && (!run || (cnt == LAST));
    end

    // Advance the cell counter while enabled, and park it when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (!run) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Split the counter into bit position and half-bit phase.
    always_comb begin
        bit_idx     = cnt[CNT_W-1:1];
        second_half = cnt[0];
    end
endmodule

// File: rtl/mtx_nibble_reg.sv
// Nibble holding register: stores the accepted nibble and selects the bit
// now being encoded. Assumes load comes from the sequencer.
module mtx_nibble_reg
    import mtx_pkg::*;
#(
    parameter int NIB_W = NIB_W_DEF,
    localparam int IDX_W = $clog2(NIB_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NIB_W-1:0] nibble_in,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             cur_bit
);
    logic [NIB_W-1:0] hold;

    // Capture the nibble on the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (load) begin
            hold <= nibble_in;
        end
    end

    // Pick the bit for the current cell, least significant first.
    always_comb begin
        cur_bit = hold[bit_idx];
    end
endmodule

// File: rtl/mtx_cell_enc.sv
// Cell encoder: maps the current bit and phase to a line level, registers
// it, and flags the second cell of a wide pulse by comparing with the level
// already on the line. Assumes run/tx_en gate the burst.
module mtx_cell_enc
    import mtx_pkg::*;
#(
    parameter pol_e POL        = POL_ONE_RISES,
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic run,
    input  logic second_half,
    input  logic cur_bit,
    output logic line_out,
    output logic drive_low
);
    logic level;
    logic emit;
    logic hist_ok;

    // Pick the level for the cell according to the polarity parameter.
    generate
        if (POL == POL_ONE_RISES) begin : g_rise
            always_comb level = second_half ? cur_bit : ~cur_bit;
        end else begin : g_fall
            always_comb level = second_half ? ~cur_bit : cur_bit;
        end
    endgenerate

    // A cell goes out only while the burst runs and enable holds.
    always_comb begin
        emit = run && tx_en;
    end

    // Register the level, the wide-pulse flag and the history-valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out  <= IDLE_LEVEL;
            drive_low <= 1'b0;
            hist_ok   <= 1'b0;
        end else if (emit) begin
            line_out  <= level;
            drive_low <= hist_ok && (level == line_out);
            hist_ok   <= 1'b1;
        end else begin
            line_out  <= IDLE_LEVEL;
            drive_low <= 1'b0;
            hist_ok   <= 1'b0;
        end
    end
endmodule

// File: rtl/mtx_manchester_tx.sv
// Top: Manchester transmit encoder with wide-pulse drive control. It joins
// the sequencer, the nibble register and the cell encoder. Assumes a single
// half-bit clock and a controller that follows nibble_req.
module mtx_manchester_tx
    import mtx_pkg::*;
#(
    parameter int   NIB_W      = NIB_W_DEF,
    parameter pol_e POL        = POL_ONE_RISES,
    parameter logic IDLE_LEVEL = 1'b0,
    localparam int  IDX_W      = $clog2(NIB_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] nibble_in,
    output logic             nibble_req,
    output logic             line_out,
    output logic             drive_low
);
    logic             run;
    logic             load;
    logic [IDX_W-1:0] bit_idx;
    logic             second_half;
    logic             cur_bit;

    mtx_cell_seq #(.NIB_W(NIB_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .run         (run),
        .load        (load),
        .bit_idx     (bit_idx),
        .second_half (second_half)
    );

    mtx_nibble_reg #(.NIB_W(NIB_W)) u_nib (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .nibble_in (nibble_in),
        .bit_idx   (bit_idx),
        .cur_bit   (cur_bit)
    );

    mtx_cell_enc #(.POL(POL), .IDLE_LEVEL(IDLE_LEVEL)) u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .run         (run),
        .second_half (second_half),
        .cur_bit     (cur_bit),
        .line_out    (line_out),
        .drive_low   (drive_low)
    );

    // The request strobe is the load decision.
    always_comb begin
        nibble_req = load;
    end
endmodule

// File: rtl/mtx_tx_chk.sv
// Checker: timing properties of the encoder outputs, bound to the top.
module mtx_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic nibble_req,
    input logic line_out,
    input logic drive_low
);
    // R5
    drive_same_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> (line_out == $past(line_out)));

    // R6
    drive_single_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |=> !drive_low);

    // R7
    req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nibble_req |-> tx_en);

    // R7
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nibble_req |=> !nibble_req);

    // R8
    idle_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!drive_low && (line_out == 1'b0)));

    // R9
    no_drive_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> ($past(tx_en, 1) && $past(tx_en, 2) && $past(tx_en, 3)));
endmodule

bind mtx_manchester_tx mtx_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .nibble_req (nibble_req),
    .line_out   (line_out),
    .drive_low  (drive_low)
);

// File: tb/mtx_manchester_tx_bench.sv
`timescale 1ns/1ps
module mtx_manchester_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] nibble_in = 4'h0;
    logic       nibble_req;
    logic       line_out;
    logic       drive_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] frame [0:7];
    int         nfr;

    always #5 clk = ~clk;

    mtx_manchester_tx u_mtx_manchester_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .nibble_in  (nibble_in),
        .nibble_req (nibble_req),
        .line_out   (line_out),
        .drive_low  (drive_low)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Send the frame list and compare every cell with a model built from it.
    task automatic run_frame(input string name);
        int   idx;
        logic prev_lvl;
        logic exp_lvl;
        logic exp_drv;
        logic b;
        int   j;
        @(negedge clk);
        tx_en = 1'b1;
        nibble_in = frame[0];
        idx = 1;
        #1 chk({"R7 first strobe ", name}, nibble_req, 1'b1);
        prev_lvl = 1'b0;
        for (int k = 0; k <= 8 * nfr; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 0) begin
                chk({"R11 still idle ", name}, line_out, 1'b0);
            end else begin
                j = k - 1;
                b = frame[j / 8][(j % 8) / 2];
                exp_lvl = (j % 2 == 1) ? b : ~b;
                exp_drv = (j > 0) && (exp_lvl == prev_lvl);
                if (j % 2 == 1)
                    chk({"R2 R3 mid-bit ", name}, line_out, exp_lvl);
                else
                    chk({"R2 R4 boundary ", name}, line_out, exp_lvl);
                if (j == 0)
                    chk({"R9 first cell drive ", name}, drive_low, 1'b0);
                else if (j % 8 == 0)
                    chk({"R10 nibble edge drive ", name}, drive_low, exp_drv);
                else
                    chk({"R5 R6 drive ", name}, drive_low, exp_drv);
                prev_lvl = exp_lvl;
            end
            chk({"R7 strobe timing ", name}, nibble_req, (k % 8 == 7));
            if (nibble_req) begin
                nibble_in = (idx < nfr) ? frame[idx] : 4'h0;
                idx++;
            end
        end
        tx_en = 1'b0;
        #1 chk({"R1 no strobe when disabled ", name}, nibble_req, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk({"R8 idle line ", name}, line_out, 1'b0);
        chk({"R8 full drive ", name}, drive_low, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset line", line_out, 1'b0);
        chk("R1 reset drive", drive_low, 1'b0);
        chk("R1 reset strobe", nibble_req, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle line", line_out, 1'b0);
        chk("R1 idle strobe", nibble_req, 1'b0);
    endtask

    task automatic test_zeros();
        nfr = 2; frame[0] = 4'h0; frame[1] = 4'h0;
        run_frame("zeros");
    endtask

    task automatic test_ones();
        nfr = 2; frame[0] = 4'hF; frame[1] = 4'hF;
        run_frame("ones");
    endtask

    task automatic test_alternate();
        nfr = 3; frame[0] = 4'h5; frame[1] = 4'h5; frame[2] = 4'hA;
        run_frame("alternate");
    endtask

    task automatic test_mixed();
        nfr = 5;
        frame[0] = 4'h3; frame[1] = 4'hC; frame[2] = 4'h9;
        frame[3] = 4'h6; frame[4] = 4'h1;
        run_frame("mixed");
    endtask

    // Drop enable while a reduced-drive cell is on the line.
    task automatic test_abort();
        @(negedge clk);
        tx_en = 1'b1;
        nibble_in = 4'h5;
        repeat (4) @(negedge clk);
        chk("R5 abort setup drive", drive_low, 1'b1);
        chk("R4 abort setup line", line_out, 1'b1);
        tx_en = 1'b0;
        #1 chk("R8 abort strobe", nibble_req, 1'b0);
        @(negedge clk);
        chk("R8 abort line idle", line_out, 1'b0);
        chk("R8 abort full drive", drive_low, 1'b0);
        nfr = 1; frame[0] = 4'h1;
        run_frame("after-abort");
    endtask

    initial begin
        test_reset();
        test_zeros();
        test_ones();
        test_alternate();
        test_mixed();
        test_abort();
        finish_run();
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end
endmodule